// File: doc/BRIEF.md
# Per-Group DMA Request Generator

This block turns the end of a conversion sequence in any of eight trigger groups into a DMA request line for that group. Each group carries an enable bit and a sticky status bit in one control word; the status bits are cleared by software writing ones to them. A done pulse from a group's sequencer sets both the request line and the status bit, but only when that group is enabled.

One global mode bit picks how an outstanding request is withdrawn. In latched mode the request stays high until the DMA engine has acknowledged it and the group's source-pending level has also dropped. In pulsed mode the acknowledge alone withdraws it. The control word is written through a single-cycle write strobe and is always readable.

Top module: `dma_req_gen`

## Requirements
- R1: After reset all enable bits, all status bits and all request outputs are 0, the mode bit reads 0 (latched), and every other bit of the read word is 0.
- R2: The enable of group n is bit n of the control word; a done pulse on group n raises its request and its status bit one cycle later only if that enable reads 1 in the cycle of the pulse.
- R3: In latched mode (bit 31 = 0) a raised request falls after the first clock edge at which its pending input is low and its acknowledge is high in that cycle or has been high at some cycle since the request was raised.
- R4: In pulsed mode (bit 31 = 1) a raised request falls after the first clock edge at which its acknowledge is high, whatever its pending input.
- R5: The status of group n is bit 16+n; writing 1 there clears it one cycle later, writing 0 there leaves it unchanged.
- R6: When a done pulse on an enabled group meets a write-1 to that group's status bit, or its request-clearing condition, in the same cycle, the status bit and the request stay 1.
- R7: Bit 31 of a write sets the mode and reads back; enable bits written read back in bits 7..0; all other bits read 0.
- R8: A fresh done pulse while a request is already high keeps it high and discards any acknowledge seen before it, so a later low pending input alone does not drop it in latched mode.
- R9: Clearing a group's enable bit leaves its outstanding request and its status bit untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control word read data |
| done_i | input | 8 | Per-group sequence-done pulse |
| pend_i | input | 8 | Per-group source-pending level |
| ack_i | input | 8 | Per-group DMA acknowledge |
| dma_req_o | output | 8 | Per-group DMA request |

## Verification
The bench builds the block with its default parameters: eight groups, the status field starting at bit 16 and the mode at bit 31. That places the highest group at enable bit 7 and status bit 23, so the full width of both fields and the gap between them are exercised against fixed bit positions. Scenarios cover both clearing rules with acknowledge before, with and after the pending level drops, set/clear collisions, re-arming of an outstanding request and disabling with a request in flight.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_PULSE = 1'b1
  } req_mode_e;
endpackage

// File: rtl/dreq_ctrl_reg.sv
module dreq_ctrl_reg
  import dma_req_pkg::*;
#(
  parameter int NUM_GRP  = 8,
  parameter int DATA_W   = 32,
  parameter int STAT_LSB = 16,
  parameter int MODE_POS = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_GRP-1:0] set_i,
  output logic [NUM_GRP-1:0] en_o,
  output logic [NUM_GRP-1:0] stat_o,
  output req_mode_e          mode_o
);
  logic [NUM_GRP-1:0] en_q, stat_q, w1c;
  req_mode_e          mode_q;

  assign w1c = wr_en_i ? wr_data_i[STAT_LSB +: NUM_GRP] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
      mode_q <= MODE_LATCH;
    end else begin
      if (wr_en_i) begin
        en_q   <= wr_data_i[NUM_GRP-1:0];
        mode_q <= req_mode_e'(wr_data_i[MODE_POS]);
      end
      // set takes priority over write-1-to-clear
      stat_q <= (stat_q & ~w1c) | set_i;
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/dreq_channel.sv
module dreq_channel
  import dma_req_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  req_mode_e mode_i,
  input  logic      raise_i,
  input  logic      ack_i,
  input  logic      pend_i,
  output logic      req_o
);
  logic req_q, seen_q, req_d, seen_d, drop;

  always_comb begin
    if (mode_i == MODE_PULSE) drop = ack_i;
    else                      drop = (seen_q | ack_i) & ~pend_i;
  end

  always_comb begin
    req_d  = req_q;
    seen_d = 1'b0;
    if (raise_i) begin
      req_d  = 1'b1;
      seen_d = 1'b0;
    end else if (req_q && drop) begin
      req_d  = 1'b0;
    end else if (req_q) begin
      seen_d = seen_q | ack_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      seen_q <= seen_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/dreq_readback.sv
module dreq_readback
  import dma_req_pkg::*;
#(
  parameter int NUM_GRP  = 8,
  parameter int DATA_W   = 32,
  parameter int STAT_LSB = 16,
  parameter int MODE_POS = 31
) (
  input  logic [NUM_GRP-1:0] en_i,
  input  logic [NUM_GRP-1:0] stat_i,
  input  req_mode_e          mode_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  always_comb begin
    rd_data_o                        = '0;
    rd_data_o[NUM_GRP-1:0]           = en_i;
    rd_data_o[STAT_LSB +: NUM_GRP]   = stat_i;
    rd_data_o[MODE_POS]              = mode_i;
  end
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int NUM_GRP  = 8,
  parameter int DATA_W   = 32,
  parameter int STAT_LSB = 16,
  parameter int MODE_POS = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [NUM_GRP-1:0] done_i,
  input  logic [NUM_GRP-1:0] pend_i,
  input  logic [NUM_GRP-1:0] ack_i,
  output logic [NUM_GRP-1:0] dma_req_o
);
  logic [NUM_GRP-1:0] en, stat, raise;
  req_mode_e          mode;

  assign raise = done_i & en;

  dreq_ctrl_reg #(
    .NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .STAT_LSB(STAT_LSB), .MODE_POS(MODE_POS)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .set_i(raise), .en_o(en), .stat_o(stat), .mode_o(mode)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_ch
    dreq_channel u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .raise_i(raise[g]),
      .ack_i(ack_i[g]), .pend_i(pend_i[g]), .req_o(dma_req_o[g])
    );
  end

  dreq_readback #(
    .NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .STAT_LSB(STAT_LSB), .MODE_POS(MODE_POS)
  ) u_rb (
    .en_i(en), .stat_i(stat), .mode_i(mode), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/dreq_checker.sv
module dreq_checker #(
  parameter int NUM_GRP  = 8,
  parameter int DATA_W   = 32,
  parameter int STAT_LSB = 16,
  parameter int MODE_POS = 31
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [NUM_GRP-1:0] done_i,
  input logic [NUM_GRP-1:0] pend_i,
  input logic [NUM_GRP-1:0] ack_i,
  input logic [NUM_GRP-1:0] dma_req_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    p_rise_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dma_req_o[g]) |-> $past(done_i[g] && rd_data_o[g]));
    p_latch_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_data_o[MODE_POS] && dma_req_o[g] && pend_i[g]) |=> dma_req_o[g]);
    p_pulse_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_data_o[MODE_POS] && dma_req_o[g] && ack_i[g] && !(done_i[g] && rd_data_o[g]))
      |=> !dma_req_o[g]);
    p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[STAT_LSB+g] && !(done_i[g] && rd_data_o[g]))
      |=> !rd_data_o[STAT_LSB+g]);
    p_stat_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_data_o[STAT_LSB+g] && !(wr_en_i && wr_data_i[STAT_LSB+g]))
      |=> rd_data_o[STAT_LSB+g]);
    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i[g] && rd_data_o[g]) |=> (rd_data_o[STAT_LSB+g] && dma_req_o[g]));
  end
endmodule

bind dma_req_gen dreq_checker #(
  .NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .STAT_LSB(STAT_LSB), .MODE_POS(MODE_POS)
) u_dreq_chk (.*);

// File: tb/dma_req_gen_tb_top.sv
module dma_req_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [7:0]  done_i = '0, pend_i = '0, ack_i = '0;
  logic [7:0]  dma_req_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  dma_req_gen dut_i (.*);

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 0; wr_data_i = '0; done_i = '0; pend_i = '0; ack_i = '0;
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic wr(logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse_done(logic [7:0] m);
    done_i = m;
    tick();
    done_i = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd_data", rd_data_o, 32'h0);
    chk("R1 req", {24'h0, dma_req_o}, 32'h0);
  endtask

  task automatic t_enable_gate();
    do_reset();
    wr(32'h0000_0085);
    chk("R7 enable readback", rd_data_o, 32'h0000_0085);
    pulse_done(8'hFF);
    chk("R2 req gated", {24'h0, dma_req_o}, 32'h85);
    chk("R2 status gated", rd_data_o, 32'h0085_0085);
  endtask

  task automatic t_latched();
    do_reset();
    wr(32'h0000_00FF);
    pulse_done(8'h06);
    pend_i = 8'h06; ack_i = 8'h02;
    tick();
    ack_i = '0;
    chk("R3 hold while pending", {24'h0, dma_req_o}, 32'h06);
    tick();
    chk("R3 hold after ack", {24'h0, dma_req_o}, 32'h06);
    pend_i = 8'h04;
    tick();
    chk("R3 drop g1 on pend low", {24'h0, dma_req_o}, 32'h04);
    pend_i = '0;
    tick();
    chk("R3 g2 waits for ack", {24'h0, dma_req_o}, 32'h04);
    ack_i = 8'h04;
    tick();
    ack_i = '0;
    chk("R3 g2 drop on ack", {24'h0, dma_req_o}, 32'h00);
  endtask

  task automatic t_pulsed();
    do_reset();
    wr(32'h8000_00FF);
    chk("R7 mode readback", rd_data_o, 32'h8000_00FF);
    pulse_done(8'h88);
    chk("R4 raised", {24'h0, dma_req_o}, 32'h88);
    pend_i = 8'h88; ack_i = 8'h08;
    tick();
    ack_i = '0;
    chk("R4 ack drops despite pend", {24'h0, dma_req_o}, 32'h80);
    pend_i = '0;
  endtask

  task automatic t_w1c();
    do_reset();
    wr(32'h0000_00FF);
    pulse_done(8'h81);
    wr(32'h0000_00F0);
    chk("R5 zero status write keeps", rd_data_o, 32'h0081_00F0);
    wr(32'h0080_00F0);
    chk("R5 w1c group 7", rd_data_o, 32'h0001_00F0);
  endtask

  task automatic t_set_wins();
    do_reset();
    wr(32'h0000_00FF);
    pulse_done(8'h10);
    done_i = 8'h10; wr_en_i = 1'b1; wr_data_i = 32'h0010_00FF; ack_i = 8'h10;
    tick();
    done_i = '0; wr_en_i = 1'b0; wr_data_i = '0; ack_i = '0;
    chk("R6 status set wins", rd_data_o, 32'h0010_00FF);
    chk("R6 req set wins", {24'h0, dma_req_o}, 32'h10);
  endtask

  task automatic t_rearm();
    do_reset();
    wr(32'h0000_00FF);
    pulse_done(8'h20);
    pend_i = 8'h20; ack_i = 8'h20;
    tick();
    ack_i = '0;
    pulse_done(8'h20);
    pend_i = '0;
    tick();
    chk("R8 old ack discarded", {24'h0, dma_req_o}, 32'h20);
    ack_i = 8'h20;
    tick();
    ack_i = '0;
    chk("R8 new ack drops", {24'h0, dma_req_o}, 32'h00);
  endtask

  task automatic t_disable();
    do_reset();
    wr(32'h0000_0040);
    pulse_done(8'h40);
    wr(32'h0000_0000);
    chk("R9 req kept", {24'h0, dma_req_o}, 32'h40);
    chk("R9 status kept", rd_data_o, 32'h0040_0000);
    pulse_done(8'h40);
    chk("R2 disabled no effect", rd_data_o, 32'h0040_0000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_enable_gate();
        t_latched();
        t_pulsed();
        t_w1c();
        t_set_wins();
        t_rearm();
        t_disable();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule